// File: doc/BRIEF.md
# Banked Vector Register File with Word Sequencers

This block holds the vector registers of a two-lane vector unit: 32 registers of 256 bits, stored in two banks. Registers 0 to 15 live in the bank owned by lane 0, and registers 16 to 31 live in the bank owned by lane 1. Each bank is private to its lane. The two lanes can therefore read and write at the same time without arbitration.

A register is visited as a sequence of 64-bit words. Each lane has a sequencer. A start pulse latches the instruction's element width, vector length, mask-enable flag and element mask. The sequencer then walks words 0 to 3, one per cycle, and reports the byte offset of the current word. For every word it also produces an 8-bit byte write enable. This enable allows only the bytes of elements that are below the vector length and, in masked mode, whose mask bit is set.

Both read ports of a bank, and its write port, address the word that the lane's sequencer currently points at. The ALU, the memory path and the instruction decode sit outside this block and drive its ports.

Top module: `vrf_banked_top`

## Requirements
- R1: A register number routes to a bank through its top bit. Bank 0 (lane 0) holds registers 0–15 and bank 1 (lane 1) holds registers 16–31. A lane's write to a register of the other bank changes nothing. A lane's read of a register of the other bank returns zero.
- R2: Each bank has two independent read ports and one write port. Both lanes can run sequences in the same cycles without disturbing each other.
- R3: In the cycle after a start pulse, the lane is busy at word 0 with offset 0. While busy, the lane advances one word per cycle, and the offset steps through 0, 8, 16 and 24 bytes.
- R4: The done flag is high only in the cycle the lane sits on word 3. In the following cycle the lane is idle, unless a new start arrived.
- R5: The element-width code sets the bytes per element: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. The element index of byte b in word w is (8·w + b) divided by the bytes per element.
- R6: With the mask-enable input at 0 (masked), an element's bytes are enabled only when bit e of the latched element mask is 1. With the input at 1, all elements below the vector length are enabled.
- R7: Bytes of elements with index at or above the latched vector length get a zero enable. A vector length of 0 yields all-zero enables. An idle lane shows all-zero enables.
- R8: On a write, a byte whose enable bit is 0 keeps its old contents, and a byte whose bit is 1 takes the new data.
- R9: A read of the word being written in the same cycle returns the old contents.
- R10: A start pulse during a running sequence restarts it at word 0 in the next cycle.
- R11: Reset leaves both lanes idle with offset 0, done low and zero enables. Register contents survive reset.
- R12: A write takes place only while the lane is busy and its write-enable input is high. With the write-enable input low, the register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencers |
| start_i | input | 2 | Per-lane start pulse |
| unmasked_i | input | 2 | Per-lane mask-enable flag: 1 = unmasked, 0 = masked by elem_mask_i |
| sew_i | input | 2x2 | Per-lane element-width code |
| vl_i | input | 2x6 | Per-lane vector length in elements |
| elem_mask_i | input | 2x32 | Per-lane element mask, bit e for element e |
| wr_en_i | input | 2 | Per-lane write enable |
| wr_reg_i | input | 2x5 | Per-lane destination register number |
| wr_data_i | input | 2x64 | Per-lane write word |
| rd_reg_a_i | input | 2x5 | Per-lane register number for read port A |
| rd_reg_b_i | input | 2x5 | Per-lane register number for read port B |
| rd_data_a_o | output | 2x64 | Per-lane read port A word |
| rd_data_b_o | output | 2x64 | Per-lane read port B word |
| busy_o | output | 2 | Lane is running a sequence |
| done_o | output | 2 | Lane is on its last word |
| offset_o | output | 2x5 | Byte offset of the current word |
| byte_en_o | output | 2x8 | Byte write enable of the current word |

## Verification
A word counter that is stuck or skips a value shows up at the offset port in the cycle it happens. A word counter that is out of step with the stored data shows up one cycle later, because the next read returns a word from the wrong position. A wrong element-index or vector-length calculation appears at once on the enable port. Its effect on the storage is only visible when the register is read back in a later sequence, so the bench follows every write with a full read-back. A bank routing error is visible on the first read of a cross-bank register, which must return zero, and on a later read-back of the register the other lane owns.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    // Element width code: log2 of the bytes per element.
    typedef enum logic [1:0] {
        SEW_B8  = 2'd0,
        SEW_B16 = 2'd1,
        SEW_B32 = 2'd2,
        SEW_B64 = 2'd3
    } sew_e;

endpackage

// File: rtl/vrf_offset_gen.sv
module vrf_offset_gen
    import vrf_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int ELEN = 64,
    localparam int BYTES  = ELEN / 8,
    localparam int WORDS  = VLEN / ELEN,
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int MAXE   = VLEN / 8,
    localparam int VL_W   = $clog2(MAXE + 1),
    localparam int BSH    = $clog2(BYTES),
    localparam int POS_W  = WORD_W + BSH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              unmasked_i,
    input  logic [1:0]        sew_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [MAXE-1:0]   elem_mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o,
    output logic [POS_W-1:0]  offset_o,
    output logic [BYTES-1:0]  byte_en_o
);

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

    typedef struct packed {
        logic              active;
        logic [WORD_W-1:0] word;
        logic              unmasked;
        sew_e              sew;
        logic [VL_W-1:0]   vl;
        logic [MAXE-1:0]   emask;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start_i) begin
            seq_d.active   = 1'b1;
            seq_d.word     = '0;
            seq_d.unmasked = unmasked_i;
            seq_d.sew      = sew_e'(sew_i);
            seq_d.vl       = vl_i;
            seq_d.emask    = elem_mask_i;
        end else if (seq_q.active) begin
            if (seq_q.word == LAST_WORD) begin
                seq_d.active = 1'b0;
            end else begin
                seq_d.word = seq_q.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Byte enables for the current word: element index from byte position.
    always_comb begin
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] elem;
        byte_en_o = '0;
        for (int b = 0; b < BYTES; b++) begin
            pos  = {seq_q.word, BSH'(b)};
            elem = pos >> seq_q.sew;
            if (seq_q.active && (VL_W'(elem) < seq_q.vl) &&
                (seq_q.unmasked || seq_q.emask[elem])) begin
                byte_en_o[b] = 1'b1;
            end
        end
    end

    assign busy_o   = seq_q.active;
    assign done_o   = seq_q.active && (seq_q.word == LAST_WORD);
    assign word_o   = seq_q.word;
    assign offset_o = {seq_q.word, {BSH{1'b0}}};

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
    parameter int REGS_PER_BANK = 16,
    parameter int WORDS         = 4,
    parameter int ELEN          = 64,
    parameter int REG_W         = 5,
    parameter int BANK_ID       = 0,
    localparam int IDX_W  = $clog2(REGS_PER_BANK),
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BYTES  = ELEN / 8,
    localparam int ROWS   = REGS_PER_BANK * WORDS
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [REG_W-1:0]  wreg_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [ELEN-1:0]   wdata_i,
    input  logic [BYTES-1:0]  wbe_i,
    input  logic [REG_W-1:0]  rreg_a_i,
    input  logic [REG_W-1:0]  rreg_b_i,
    output logic [ELEN-1:0]   rdata_a_o,
    output logic [ELEN-1:0]   rdata_b_o
);

    localparam logic [REG_W-IDX_W-1:0] MY_ID = (REG_W - IDX_W)'(BANK_ID);

    logic [BYTES-1:0][7:0] mem_q [ROWS];

    logic hit_w, hit_a, hit_b;
    assign hit_w = (wreg_i[REG_W-1:IDX_W]   == MY_ID);
    assign hit_a = (rreg_a_i[REG_W-1:IDX_W] == MY_ID);
    assign hit_b = (rreg_b_i[REG_W-1:IDX_W] == MY_ID);

    // Contents carry no reset; only enabled bytes change.
    always_ff @(posedge clk_i) begin
        if (we_i && hit_w) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wbe_i[b]) begin
                    mem_q[{wreg_i[IDX_W-1:0], word_i}][b] <= wdata_i[8*b +: 8];
                end
            end
        end
    end

    assign rdata_a_o = hit_a ? mem_q[{rreg_a_i[IDX_W-1:0], word_i}] : '0;
    assign rdata_b_o = hit_b ? mem_q[{rreg_b_i[IDX_W-1:0], word_i}] : '0;

endmodule

// File: rtl/vrf_banked_top.sv
module vrf_banked_top #(
    parameter int NUM_REGS  = 32,
    parameter int NUM_BANKS = 2,
    parameter int VLEN      = 256,
    parameter int ELEN      = 64,
    localparam int BYTES  = ELEN / 8,
    localparam int WORDS  = VLEN / ELEN,
    localparam int MAXE   = VLEN / 8,
    localparam int VL_W   = $clog2(MAXE + 1),
    localparam int OFF_W  = $clog2(MAXE),
    localparam int REG_W  = $clog2(NUM_REGS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_BANKS-1:0]             start_i,
    input  logic [NUM_BANKS-1:0]             unmasked_i,
    input  logic [NUM_BANKS-1:0][1:0]        sew_i,
    input  logic [NUM_BANKS-1:0][VL_W-1:0]   vl_i,
    input  logic [NUM_BANKS-1:0][MAXE-1:0]   elem_mask_i,
    input  logic [NUM_BANKS-1:0]             wr_en_i,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  wr_reg_i,
    input  logic [NUM_BANKS-1:0][ELEN-1:0]   wr_data_i,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  rd_reg_a_i,
    input  logic [NUM_BANKS-1:0][REG_W-1:0]  rd_reg_b_i,
    output logic [NUM_BANKS-1:0][ELEN-1:0]   rd_data_a_o,
    output logic [NUM_BANKS-1:0][ELEN-1:0]   rd_data_b_o,
    output logic [NUM_BANKS-1:0]             busy_o,
    output logic [NUM_BANKS-1:0]             done_o,
    output logic [NUM_BANKS-1:0][OFF_W-1:0]  offset_o,
    output logic [NUM_BANKS-1:0][BYTES-1:0]  byte_en_o
);

    localparam int REGS_PER_BANK = NUM_REGS / NUM_BANKS;
    localparam int WORD_W        = (WORDS > 1) ? $clog2(WORDS) : 1;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_lane
        logic [WORD_W-1:0] word;

        vrf_offset_gen #(
            .VLEN (VLEN),
            .ELEN (ELEN)
        ) u_seq (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .start_i     (start_i[g]),
            .unmasked_i  (unmasked_i[g]),
            .sew_i       (sew_i[g]),
            .vl_i        (vl_i[g]),
            .elem_mask_i (elem_mask_i[g]),
            .busy_o      (busy_o[g]),
            .done_o      (done_o[g]),
            .word_o      (word),
            .offset_o    (offset_o[g]),
            .byte_en_o   (byte_en_o[g])
        );

        vrf_bank #(
            .REGS_PER_BANK (REGS_PER_BANK),
            .WORDS         (WORDS),
            .ELEN          (ELEN),
            .REG_W         (REG_W),
            .BANK_ID       (g)
        ) u_bank (
            .clk_i     (clk_i),
            .we_i      (wr_en_i[g] && busy_o[g]),
            .wreg_i    (wr_reg_i[g]),
            .word_i    (word),
            .wdata_i   (wr_data_i[g]),
            .wbe_i     (byte_en_o[g]),
            .rreg_a_i  (rd_reg_a_i[g]),
            .rreg_b_i  (rd_reg_b_i[g]),
            .rdata_a_o (rd_data_a_o[g]),
            .rdata_b_o (rd_data_b_o[g])
        );
    end

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
    parameter int NUM_BANKS = 2,
    parameter int OFF_W     = 5,
    parameter int BYTES     = 8,
    parameter int WORDS     = 4
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic [NUM_BANKS-1:0]            start_i,
    input logic [NUM_BANKS-1:0]            busy_o,
    input logic [NUM_BANKS-1:0]            done_o,
    input logic [NUM_BANKS-1:0][OFF_W-1:0] offset_o,
    input logic [NUM_BANKS-1:0][BYTES-1:0] byte_en_o
);

    localparam logic [OFF_W-1:0] STEP     = OFF_W'(BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((WORDS - 1) * BYTES);

    for (genvar l = 0; l < NUM_BANKS; l++) begin : g_chk
        // R10: a start always lands on word 0
        p_start_word0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            start_i[l] |=> (busy_o[l] && offset_o[l] == '0));

        // R3: one word per cycle while running
        p_word_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (busy_o[l] && !done_o[l] && !start_i[l]) |=>
            (busy_o[l] && offset_o[l] == OFF_W'($past(offset_o[l]) + STEP)));

        // R4: done only on the last word
        p_done_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o[l] |-> (busy_o[l] && offset_o[l] == LAST_OFF));

        // R4: idle after the last word unless restarted
        p_idle_after_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_o[l] && !start_i[l]) |=> !busy_o[l]);

        // R7: an idle lane enables nothing
        p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !busy_o[l] |-> (byte_en_o[l] == '0 && !done_o[l]));
    end

endmodule

bind vrf_banked_top vrf_checker #(
    .NUM_BANKS (NUM_BANKS),
    .OFF_W     (OFF_W),
    .BYTES     (BYTES),
    .WORDS     (WORDS)
) u_vrf_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .offset_o  (offset_o),
    .byte_en_o (byte_en_o)
);

// File: tb/tb_vrf_banked_top.sv
module tb_vrf_banked_top;

    localparam int CLK_PERIOD = 10;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic [1:0]        start_i = '0;
    logic [1:0]        unmasked_i = '0;
    logic [1:0][1:0]   sew_i = '0;
    logic [1:0][5:0]   vl_i = '0;
    logic [1:0][31:0]  elem_mask_i = '0;
    logic [1:0]        wr_en_i = '0;
    logic [1:0][4:0]   wr_reg_i = '0;
    logic [1:0][63:0]  wr_data_i = '0;
    logic [1:0][4:0]   rd_reg_a_i = '0;
    logic [1:0][4:0]   rd_reg_b_i = '0;
    logic [1:0][63:0]  rd_data_a_o, rd_data_b_o;
    logic [1:0]        busy_o, done_o;
    logic [1:0][4:0]   offset_o;
    logic [1:0][7:0]   byte_en_o;

    int checks = 0;
    int errors = 0;
    logic [255:0] shadow [32];

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    vrf_banked_top dut (
        .clk_i, .rst_ni, .start_i, .unmasked_i, .sew_i, .vl_i, .elem_mask_i,
        .wr_en_i, .wr_reg_i, .wr_data_i, .rd_reg_a_i, .rd_reg_b_i,
        .rd_data_a_o, .rd_data_b_o, .busy_o, .done_o, .offset_o, .byte_en_o
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_be(int w, int sw, int vl, bit unm, logic [31:0] m);
        logic [7:0] r = '0;
        for (int b = 0; b < 8; b++) begin
            int e = (w * 8 + b) >> sw;
            r[b] = (e < vl) && (unm || m[e]);
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_rd(int ln, int rg, int w);
        return (rg / 16 == ln) ? shadow[rg][64*w +: 64] : 64'd0;
    endfunction

    function automatic logic [255:0] pat(logic [7:0] s);
        logic [255:0] r;
        for (int i = 0; i < 32; i++) r[8*i +: 8] = s + 8'(i * 7);
        return r;
    endfunction

    // One full sequence on one lane, with per-word checks.
    task automatic do_seq(int ln, int rg, int sw, int vl, bit unm, logic [31:0] m,
                          bit wen, logic [255:0] d, int rda, int rdb, bit chk, string tag);
        @(negedge clk_i);
        start_i[ln] = 1'b1;
        unmasked_i[ln] = unm;
        sew_i[ln] = 2'(sw);
        vl_i[ln] = 6'(vl);
        elem_mask_i[ln] = m;
        wr_reg_i[ln] = 5'(rg);
        rd_reg_a_i[ln] = 5'(rda);
        rd_reg_b_i[ln] = 5'(rdb);
        for (int w = 0; w < 4; w++) begin
            logic [7:0] be;
            @(negedge clk_i);
            start_i[ln] = 1'b0;
            be = exp_be(w, sw, vl, unm, m);
            check("R3", "busy", 64'(busy_o[ln]), 64'd1);
            check("R3", "offset", 64'(offset_o[ln]), 64'(w * 8));
            check("R4", "done", 64'(done_o[ln]), 64'(w == 3));
            check(tag, "byte enable", 64'(byte_en_o[ln]), 64'(be));
            if (chk) begin
                check((rda == rg) ? "R9" : "R1", "read A", rd_data_a_o[ln], exp_rd(ln, rda, w));
                check((rdb / 16 != ln) ? "R1" : "R2", "read B", rd_data_b_o[ln], exp_rd(ln, rdb, w));
            end
            wr_en_i[ln] = wen;
            wr_data_i[ln] = d[64*w +: 64];
            if (wen && (rg / 16 == ln)) begin
                for (int b = 0; b < 8; b++)
                    if (be[b]) shadow[rg][64*w + 8*b +: 8] = d[64*w + 8*b +: 8];
            end
        end
        @(negedge clk_i);
        wr_en_i[ln] = 1'b0;
        check("R4", "idle after last", 64'(busy_o[ln]), 64'd0);
        check("R7", "idle enable", 64'(byte_en_o[ln]), 64'd0);
    endtask

    task automatic readback(int ln, int rg, string tag);
        do_seq(ln, rg, 3, 4, 1'b1, 32'd0, 1'b0, pat(8'hEE), rg, (ln == 0) ? 16 : 0, 1'b1, tag);
    endtask

    task automatic t_reset_state();
        for (int l = 0; l < 2; l++) begin
            check("R11", "busy at reset", 64'(busy_o[l]), 64'd0);
            check("R11", "done at reset", 64'(done_o[l]), 64'd0);
            check("R11", "offset at reset", 64'(offset_o[l]), 64'd0);
            check("R11", "enable at reset", 64'(byte_en_o[l]), 64'd0);
        end
    endtask

    task automatic t_fill_both_lanes();
        fork
            do_seq(0, 3, 3, 4, 1'b1, 32'd0, 1'b1, pat(8'h10), 3, 16, 1'b0, "R5");
            do_seq(1, 20, 3, 4, 1'b1, 32'd0, 1'b1, pat(8'h40), 20, 3, 1'b0, "R5");
        join
        fork
            do_seq(0, 5, 3, 4, 1'b1, 32'd0, 1'b1, pat(8'h70), 3, 20, 1'b1, "R2");
            do_seq(1, 17, 3, 4, 1'b1, 32'd0, 1'b1, pat(8'hA0), 20, 3, 1'b1, "R2");
        join
        readback(0, 5, "R2");
        readback(1, 17, "R2");
    endtask

    task automatic t_sew8_partial();
        do_seq(0, 3, 0, 13, 1'b1, 32'd0, 1'b1, pat(8'hC1), 3, 5, 1'b1, "R7");
        readback(0, 3, "R8");
    endtask

    task automatic t_sew16_masked();
        do_seq(1, 20, 1, 16, 1'b0, 32'h0000_A5C3, 1'b1, pat(8'h33), 20, 17, 1'b1, "R6");
        readback(1, 20, "R8");
    endtask

    task automatic t_sew32_masked();
        do_seq(0, 5, 2, 7, 1'b0, 32'h0000_006D, 1'b1, pat(8'h5A), 5, 3, 1'b1, "R5");
        readback(0, 5, "R6");
    endtask

    task automatic t_vl_zero();
        do_seq(0, 5, 3, 0, 1'b1, 32'd0, 1'b1, pat(8'h99), 5, 3, 1'b1, "R7");
        readback(0, 5, "R7");
    endtask

    task automatic t_wrong_bank_write();
        do_seq(0, 17, 3, 4, 1'b1, 32'd0, 1'b1, pat(8'h0F), 3, 17, 1'b1, "R1");
        readback(1, 17, "R1");
    endtask

    task automatic t_write_disabled();
        do_seq(1, 20, 3, 4, 1'b1, 32'd0, 1'b0, pat(8'h77), 20, 17, 1'b1, "R12");
        readback(1, 20, "R12");
    endtask

    task automatic t_restart();
        @(negedge clk_i);
        start_i[0] = 1'b1; unmasked_i[0] = 1'b1; sew_i[0] = 2'd3; vl_i[0] = 6'd4;
        @(negedge clk_i);
        start_i[0] = 1'b0;
        check("R10", "first word offset", 64'(offset_o[0]), 64'd0);
        @(negedge clk_i);
        check("R10", "second word offset", 64'(offset_o[0]), 64'd8);
        start_i[0] = 1'b1;
        @(negedge clk_i);
        start_i[0] = 1'b0;
        check("R10", "restart offset", 64'(offset_o[0]), 64'd0);
        check("R10", "restart busy", 64'(busy_o[0]), 64'd1);
        for (int w = 1; w < 4; w++) begin
            @(negedge clk_i);
            check("R10", "offset after restart", 64'(offset_o[0]), 64'(w * 8));
            check("R4", "done after restart", 64'(done_o[0]), 64'(w == 3));
        end
        @(negedge clk_i);
        check("R4", "idle after restart", 64'(busy_o[0]), 64'd0);
    endtask

    task automatic t_reset_keeps_data();
        @(negedge clk_i);
        start_i[1] = 1'b1; unmasked_i[1] = 1'b1; sew_i[1] = 2'd3; vl_i[1] = 6'd4;
        @(negedge clk_i);
        start_i[1] = 1'b0;
        rst_ni = 1'b0;
        #1;
        check("R11", "busy cleared by reset", 64'(busy_o[1]), 64'd0);
        check("R11", "offset cleared by reset", 64'(offset_o[1]), 64'd0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        readback(0, 3, "R11");
        readback(1, 20, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset_state();
        rst_ni = 1'b1;
        t_fill_both_lanes();
        t_sew8_partial();
        t_sew16_masked();
        t_sew32_masked();
        t_vl_zero();
        t_wrong_bank_write();
        t_write_disabled();
        t_restart();
        t_reset_keeps_data();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        errors++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule